// File: doc/BRIEF.md
# Serial Receive Half-Word Packer

This block is the receive front end of a synchronous serial port. It samples a serial data line on the falling edge of the serial clock, most significant bit first. Each byte fills the eight serial clocks that follow a sampled frame-sync pulse. The frame pulse for the next byte may coincide with the last bit of the current byte, so bytes can arrive back to back. While the link is idle, the serial clock is held static low, and the data line then has no effect.

Each completed byte crosses into the system clock domain through a toggle handshake and a chain of synchroniser flops. A three-state controller then pairs the bytes. The first byte of a pair is held as a pending residual byte. When the second byte arrives, the controller issues one FIFO write carrying a 16-bit half-word. A pop strobe, which comes from a register write, flushes a lone residual byte on its own. That byte goes out in the upper byte position with zeros in the lower byte. The FIFO storage, the register decode and the interrupts sit outside this block.

Top module: `ser_rx_hw_packer`

## Requirements
- R1: After reset, no byte is pending and `fifo_wr` is low. A pop strobe issued right after reset produces no write.
- R2: A byte is taken from the eight `ser_data` values sampled on the falling edges of `ser_clk` that follow a falling edge where `ser_frame` is high. The first of these values is bit 7.
- R3: When `ser_frame` is high on the falling edge that carries bit 0 of a byte, the next byte starts straight away with no idle clock, and every byte in such a run is received.
- R4: The first byte of a pair is held and causes no write. When the second byte completes, exactly one write occurs, with the first byte in `fifo_wdata[15:8]` and the second byte in `fifo_wdata[7:0]`.
- R5: A pop strobe while a byte is pending produces exactly one write of {pending byte, 8'h00}. Afterwards no byte is pending.
- R6: A pop strobe while no byte is pending produces no write.
- R7: `fifo_wr` is high for one system clock per half-word and is never high on two consecutive cycles.
- R8: The first byte received after a pop flush starts a new pair in the upper byte position.
- R9: Serial clocks with `ser_frame` held low capture nothing, whatever `ser_data` does, and they do not disturb the pairing of the bytes that follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| ser_clk | input | 1 | Serial bit clock; data is sampled on its falling edge; held low when idle |
| ser_frame | input | 1 | Receive frame-sync; high on the falling edge before a byte's MSB |
| ser_data | input | 1 | Serial receive data, MSB first |
| pop_strobe | input | 1 | One-cycle strobe (system clock) that flushes a pending residual byte |
| fifo_wdata | output | 16 | Half-word to be written into the receive FIFO |
| fifo_wr | output | 1 | FIFO write enable, one cycle per half-word |

## Verification
The hardest situation to reach is the residual-byte state meeting a pop, and then the next byte being correctly realigned into the upper position. The serial clock is asynchronous to the system clock, so the moment a byte reaches the controller is not visible at the ports. The stimulus therefore ends odd-length back-to-back runs, waits well past the handshake latency, and only then pops. The bench sends a pop into an empty controller, a second pop after a flush, and stretches of framing-free serial clocks between pairs. Its behavioural model tracks the pending byte and accepts each expected write within a bounded latency window.

// File: rtl/ser_rx_pkg.sv
package ser_rx_pkg;
   // Pairing controller states
   typedef enum logic [1:0] {
      PK_EMPTY = 2'd0,   // nothing held
      PK_RESID = 2'd1,   // one byte held, awaiting partner or pop
      PK_FLUSH = 2'd2    // half-word presented to the FIFO this cycle
   } pk_state_t;

   localparam int unsigned DEF_BYTE_W      = 8;
   localparam int unsigned DEF_SYNC_STAGES = 2;
endpackage

// File: rtl/ser_rx_shifter.sv
module ser_rx_shifter #(
   parameter int unsigned BYTE_W = 8
) (
   input  logic              ser_clk,
   input  logic              rst_n,
   input  logic              ser_frame,
   input  logic              ser_data,
   output logic [BYTE_W-1:0] hold_byte,
   output logic              done_tog
);
   localparam int unsigned CNT_W = $clog2(BYTE_W + 1);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
   localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

   logic [CNT_W-1:0]  bits_left;
   logic [BYTE_W-1:0] shreg;
   logic [BYTE_W-1:0] shnext;

   assign shnext = {shreg[BYTE_W-2:0], ser_data};

   // Falling-edge capture; a frame is accepted when idle or on the final bit
   always_ff @(negedge ser_clk or negedge rst_n) begin
      if (!rst_n) begin
         bits_left <= '0;
         shreg     <= '0;
         hold_byte <= '0;
         done_tog  <= 1'b0;
      end else begin
         if (bits_left != '0) begin
            shreg     <= shnext;
            bits_left <= bits_left - CNT_ONE;
            if (bits_left == CNT_ONE) begin
               hold_byte <= shnext;
               done_tog  <= ~done_tog;
            end
         end
         if (ser_frame && (bits_left <= CNT_ONE)) begin
            bits_left <= CNT_FULL;
         end
      end
   end
endmodule

// File: rtl/ser_rx_tsync.sv
module ser_rx_tsync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tog_in,
   output logic pulse
);
   logic [STAGES-1:0] chain;
   logic              last_q;

   genvar i;
   generate
      for (i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= 1'b0;
               else        chain[0] <= tog_in;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[i] <= 1'b0;
               else        chain[i] <= chain[i-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last_q <= 1'b0;
      else        last_q <= chain[STAGES-1];
   end

   assign pulse = chain[STAGES-1] ^ last_q;
endmodule

// File: rtl/ser_rx_pairer.sv
module ser_rx_pairer
   import ser_rx_pkg::*;
#(
   parameter int unsigned BYTE_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                byte_vld,
   input  logic [BYTE_W-1:0]   byte_bus,
   input  logic                pop,
   output logic                pend,
   output logic [2*BYTE_W-1:0] wdata,
   output logic                wr
);
   pk_state_t         st;
   logic [BYTE_W-1:0] upper;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= PK_EMPTY;
         upper <= '0;
         wdata <= '0;
      end else begin
         unique case (st)
            PK_EMPTY: begin
               if (byte_vld) begin
                  upper <= byte_bus;
                  st    <= PK_RESID;
               end
            end
            PK_RESID: begin
               // a completing byte wins over a simultaneous pop
               if (byte_vld) begin
                  wdata <= {upper, byte_bus};
                  st    <= PK_FLUSH;
               end else if (pop) begin
                  wdata <= {upper, {BYTE_W{1'b0}}};
                  st    <= PK_FLUSH;
               end
            end
            PK_FLUSH: begin
               if (byte_vld) begin
                  upper <= byte_bus;
                  st    <= PK_RESID;
               end else begin
                  st    <= PK_EMPTY;
               end
            end
            default: st <= PK_EMPTY;
         endcase
      end
   end

   assign pend = (st == PK_RESID);
   assign wr   = (st == PK_FLUSH);
endmodule

// File: rtl/ser_rx_hw_packer.sv
module ser_rx_hw_packer #(
   parameter int unsigned BYTE_W      = ser_rx_pkg::DEF_BYTE_W,
   parameter int unsigned SYNC_STAGES = ser_rx_pkg::DEF_SYNC_STAGES
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                ser_clk,
   input  logic                ser_frame,
   input  logic                ser_data,
   input  logic                pop_strobe,
   output logic [2*BYTE_W-1:0] fifo_wdata,
   output logic                fifo_wr
);
   generate
      if (BYTE_W < 2) begin : g_bad_width
         $error("ser_rx_hw_packer: BYTE_W must be at least 2");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("ser_rx_hw_packer: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [BYTE_W-1:0] hold_byte;
   logic              done_tog;
   logic              byte_vld;
   logic              pair_pend;

   ser_rx_shifter #(.BYTE_W(BYTE_W)) u_shift (
      .ser_clk   (ser_clk),
      .rst_n     (rst_n),
      .ser_frame (ser_frame),
      .ser_data  (ser_data),
      .hold_byte (hold_byte),
      .done_tog  (done_tog)
   );

   ser_rx_tsync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .tog_in (done_tog),
      .pulse  (byte_vld)
   );

   ser_rx_pairer #(.BYTE_W(BYTE_W)) u_pair (
      .clk      (clk),
      .rst_n    (rst_n),
      .byte_vld (byte_vld),
      .byte_bus (hold_byte),
      .pop      (pop_strobe),
      .pend     (pair_pend),
      .wdata    (fifo_wdata),
      .wr       (fifo_wr)
   );
endmodule

// File: rtl/ser_rx_hw_packer_chk.sv
module ser_rx_hw_packer_chk #(
   parameter int unsigned BYTE_W = 8
) (
   input logic                clk,
   input logic                rst_n,
   input logic                pop_strobe,
   input logic                byte_vld,
   input logic [BYTE_W-1:0]   byte_bus,
   input logic                pair_pend,
   input logic [2*BYTE_W-1:0] fifo_wdata,
   input logic                fifo_wr
);
   // R1: held in reset means no write
   p_reset_quiet_r1: assert property (@(posedge clk)
      !rst_n |-> !fifo_wr);

   // R7: single-cycle write pulse
   p_single_wr_r7: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_wr |=> !fifo_wr);

   // R4: second byte of a pair lands in the lower byte, one cycle later
   p_pair_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_vld && pair_pend) |=>
         (fifo_wr && fifo_wdata[BYTE_W-1:0] == $past(byte_bus)));

   // R5: pop with a residual byte flushes it with a zero lower byte
   p_pop_flush_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_strobe && pair_pend && !byte_vld) |=>
         (fifo_wr && fifo_wdata[BYTE_W-1:0] == '0 && !pair_pend));

   // R6: pop with nothing pending writes nothing
   p_pop_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_strobe && !pair_pend && !byte_vld) |=> !fifo_wr);

   // R4: a write always follows a byte arrival or a pop
   p_wr_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_wr |-> $past(byte_vld || pop_strobe));
endmodule

bind ser_rx_hw_packer ser_rx_hw_packer_chk #(.BYTE_W(BYTE_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .pop_strobe (pop_strobe),
   .byte_vld   (byte_vld),
   .byte_bus   (hold_byte),
   .pair_pend  (pair_pend),
   .fifo_wdata (fifo_wdata),
   .fifo_wr    (fifo_wr)
);

// File: tb/tb_ser_rx_hw_packer.sv
`timescale 1ns/1ps
module tb_ser_rx_hw_packer;
   localparam real HALF    = 20.0;
   localparam int  LAT_MAX = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ser_clk = 1'b0;
   logic        ser_frame = 1'b0;
   logic        ser_data = 1'b0;
   logic        pop_strobe = 1'b0;
   logic [15:0] fifo_wdata;
   logic        fifo_wr;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int wr_count = 0;
   bit done = 0;
   bit prev_wr = 0;

   // behavioural model
   bit          m_pend = 0;
   logic [7:0]  m_byte = '0;
   logic [15:0] exp_data[$];
   string       exp_tag[$];
   int          exp_cyc[$];

   ser_rx_hw_packer dut (
      .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_frame(ser_frame),
      .ser_data(ser_data), .pop_strobe(pop_strobe),
      .fifo_wdata(fifo_wdata), .fifo_wr(fifo_wr)
   );

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h (t=%0t)", tag, act, exp, $time);
      end
   endtask

   task automatic model_byte(input logic [7:0] b, input string tag);
      if (m_pend) begin
         exp_data.push_back({m_byte, b});
         exp_tag.push_back(tag);
         exp_cyc.push_back(cyc);
         m_pend = 0;
      end else begin
         m_pend = 1;
         m_byte = b;
      end
   endtask

   task automatic model_pop(input string tag);
      if (m_pend) begin
         exp_data.push_back({m_byte, 8'h00});
         exp_tag.push_back(tag);
         exp_cyc.push_back(cyc);
         m_pend = 0;
      end
   endtask

   // compare against the model on every clock, away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         if (fifo_wr) begin
            wr_count++;
            check(!prev_wr, "R7 back-to-back write", 32'(fifo_wr), 32'd0);
            if (exp_data.size() == 0) begin
               check(1'b0, "R6 R9 unexpected write", 32'(fifo_wdata), 32'hxxxx);
            end else begin
               check(fifo_wdata == exp_data[0], exp_tag[0], 32'(fifo_wdata), 32'(exp_data[0]));
               void'(exp_data.pop_front());
               void'(exp_tag.pop_front());
               void'(exp_cyc.pop_front());
            end
         end else if (exp_data.size() != 0 && (cyc - exp_cyc[0]) > LAT_MAX) begin
            check(1'b0, {exp_tag[0], " write missing"}, 32'd0, 32'(exp_data[0]));
            void'(exp_data.pop_front());
            void'(exp_tag.pop_front());
            void'(exp_cyc.pop_front());
         end
      end
      prev_wr = fifo_wr;
   end

   task automatic ser_cycle(input logic f, input logic d, input bit fin,
                            input logic [7:0] b, input string tag);
      ser_clk = 1'b1; ser_frame = f; ser_data = d;
      #(HALF);
      ser_clk = 1'b0;
      if (fin) model_byte(b, tag);
      #(HALF);
   endtask

   // first byte in the highest used lane of pk
   task automatic send_run(input int n, input logic [63:0] pk, input string tag);
      ser_cycle(1'b1, 1'b0, 1'b0, 8'h00, tag);
      for (int i = 0; i < n; i++) begin
         logic [7:0] b;
         b = pk[8*(n-1-i) +: 8];
         for (int k = 7; k >= 0; k--) begin
            ser_cycle((k == 0) && (i < n-1), b[k], k == 0, b, tag);
         end
      end
      ser_frame = 1'b0; ser_data = 1'b0;
      repeat (12) @(negedge clk);
   endtask

   task automatic do_pop(input string tag);
      @(negedge clk);
      pop_strobe = 1'b1;
      model_pop(tag);
      @(negedge clk);
      pop_strobe = 1'b0;
      repeat (12) @(negedge clk);
   endtask

   task automatic expect_no_write(input int base, input string tag);
      repeat (20) @(negedge clk);
      check(wr_count == base, tag, 32'(wr_count), 32'(base));
   endtask

   initial begin
      int base;
      repeat (6) @(negedge clk);
      check(fifo_wr == 1'b0, "R1 wr low in reset", 32'(fifo_wr), 32'd0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      check(fifo_wr == 1'b0, "R1 wr low after reset", 32'(fifo_wr), 32'd0);

      // R1: pop right after reset does nothing
      base = wr_count;
      do_pop("R1");
      expect_no_write(base, "R1 pop after reset");

      // R2 R4: two standalone bytes
      base = wr_count;
      send_run(1, 64'hA5, "R2 R4");
      expect_no_write(base, "R4 first byte held");
      send_run(1, 64'h3C, "R2 R4");
      repeat (20) @(negedge clk);
      check(wr_count == base + 1, "R4 one write per pair", 32'(wr_count), 32'(base + 1));

      // R3: continuous run of four bytes, extreme values included
      send_run(4, 64'h00FF_8001, "R3");
      send_run(4, 64'h1122_3344, "R3");

      // R5: byte then pop
      send_run(1, 64'h9F, "R5");
      do_pop("R5");

      // R6: pop with nothing pending, and a second pop after a flush
      base = wr_count;
      do_pop("R6");
      expect_no_write(base, "R6 idle pop");

      // R8: fresh pair after flush
      send_run(2, 64'h7788, "R8");

      // R9: clocks with frame low and toggling data
      base = wr_count;
      for (int i = 0; i < 20; i++) ser_cycle(1'b0, (i % 3) == 0, 1'b0, 8'h00, "R9");
      expect_no_write(base, "R9 no frame no capture");
      send_run(2, 64'hC35A, "R9");

      // R3 R5: odd-length continuous run then pop, then another pop
      send_run(3, 64'h010203, "R3 R5");
      do_pop("R5");
      base = wr_count;
      do_pop("R6");
      expect_no_write(base, "R6 second pop");

      // R8: single byte pairs with next run's first byte after flush state
      send_run(1, 64'hE7, "R8");
      send_run(1, 64'h42, "R8");

      repeat (40) @(negedge clk);
      check(exp_data.size() == 0, "R4 R5 all writes seen", 32'(exp_data.size()), 32'd0);
      check(m_pend == 1'b0, "R4 model drained", 32'(m_pend), 32'd0);

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule